// File: doc/BRIEF.md
# Payload Read Request Generator

This block turns the transfer fields of an already validated descriptor into a sequence of (address, length) read requests for a memory port. A one-cycle start pulse captures every descriptor field. The block then issues one request at a time over a valid/ready handshake. It signals the end of the job with a one-cycle done pulse, or with a one-cycle error pulse if the job is aborted. Data movement and descriptor fetching belong to neighbouring blocks.

There are two modes. Line mode walks a two-dimensional region. Each request covers one line, and the address steps by a stride given in 16-byte units. Fragment mode walks up to five separate source buffers in order. Each fragment reaches exactly as far as the next 4 KiB boundary. In both modes the last request is clipped so that the total never exceeds the transfer size. A read error reported by memory stops the job at once.

Top module: `pldreq_gen`

## Requirements
- R1: While reset is held and after its release with no start, `req_valid_o`, `done_o` and `err_o` are low.
- R2: In line mode (`frag_mode_i`=0), the line size is `line_word_i[17:0]` and the stride is `line_word_i[31:18]` times 16. The first request address is `{addr_ext_i[0][27:16], src_base_i[0]}`. Each accepted request advances the address by the stride, modulo 2^44. The length of each request is the line size.
- R3: A line-mode job ends when the bytes still to request reach zero. The final request length is the smaller of the line size and that remainder. `done_o` pulses in the cycle after the final request is accepted.
- R4: In fragment mode (`frag_mode_i`=1), fragment f is requested at `{ext_f, src_base_i[f]}`. The 12-bit upper field ext_f is `addr_ext_i[0][27:16]` for f=0, `addr_ext_i[1][11:0]` for f=1, `addr_ext_i[1][27:16]` for f=2, `addr_ext_i[2][11:0]` for f=3 and `addr_ext_i[2][27:16]` for f=4. Fragments are issued in the order 0 to 4. Each length is 4096 minus (address mod 4096), clipped to the remainder.
- R5: A fragment-mode job ends with `done_o` when the remainder is consumed or after fragment 4 is accepted, whichever happens first.
- R6: While `req_valid_o` is high and `req_ready_i` is low, the request stays valid and its address and length do not change.
- R7: `mem_err_i` high while a request is pending aborts the job. In the next cycle `req_valid_o` is low, `err_o` pulses and `done_o` stays low.
- R8: A line-mode start with a zero line size and a nonzero transfer size issues no request and pulses `err_o` in the cycle after start.
- R9: A start with a zero transfer size issues no request and pulses `done_o` in the cycle after start, in either mode.
- R10: `start_i` is ignored while a job runs. All descriptor inputs are captured at start, and later changes to them do not alter the running sequence.
- R11: `done_o` and `err_o` are never high together, and every issued request has a nonzero length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures the descriptor fields |
| frag_mode_i | input | 1 | 0 = line mode, 1 = fragment mode |
| xfer_size_i | input | 32 | Total bytes to request |
| line_word_i | input | 32 | Line size [17:0] and stride in 16-byte units [31:18] |
| src_base_i | input | 5x32 | Lower 32 address bits of each fragment (entry 0 also used by line mode) |
| addr_ext_i | input | 3x32 | Extension words holding the 12-bit upper address fields |
| req_valid_o | output | 1 | Request pending |
| req_ready_i | input | 1 | Memory accepts the pending request |
| req_addr_o | output | 44 | Request byte address |
| req_len_o | output | 18 | Request byte count |
| mem_err_i | input | 1 | Memory read error; aborts the job |
| done_o | output | 1 | One-cycle pulse on normal completion |
| err_o | output | 1 | One-cycle pulse on abort or zero line size |

## Verification
The bench builds the block with its default parameters: five fragments, 12-bit extensions over a 32-bit base, an 18-bit line size and 4 KiB pages. Line mode is swept over a grid of line sizes, stride fields and transfer sizes. The grid covers both exact multiples of the line size and clipped final lines, and it includes an address that wraps at 2^44. Fragment mode is swept over page offsets of 0, 1, half a page and the last byte, across transfer sizes from one byte to beyond five pages. This reaches the clipped fragment, the five-fragment stop and every extension lane. Several ready patterns, aborts, restarts while busy and zero-size starts are run on top of the sweeps.

// File: rtl/pldreq_pkg.sv
package pldreq_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} st_e;
  typedef enum logic {MODE_LINES = 1'b0, MODE_FRAGS = 1'b1} mode_e;
endpackage

// File: rtl/pldreq_frag_addr.sv
module pldreq_frag_addr #(
  parameter int FRAG_N    = 5,
  parameter int BASE_W    = 32,
  parameter int EXT_W     = 12,
  parameter int WORD_W    = 32,
  parameter int EXT_WORDS = 3,
  parameter int HI_LSB    = 16,
  localparam int ADDR_W   = BASE_W + EXT_W
) (
  input  logic [FRAG_N-1:0][BASE_W-1:0]    base_i,
  input  logic [EXT_WORDS-1:0][WORD_W-1:0] ext_i,
  output logic [FRAG_N-1:0][ADDR_W-1:0]    addr_o
);
  // fragment 0 uses the high lane of word 0; others pair low/high lanes of later words
  for (genvar f = 0; f < FRAG_N; f++) begin : g_frag
    localparam int WSEL = (f + 1) / 2;
    localparam int LSB  = (f % 2 == 1) ? 0 : HI_LSB;
    assign addr_o[f] = {ext_i[WSEL][LSB +: EXT_W], base_i[f]};
  end

  logic unused_ext;
  assign unused_ext = ^ext_i;
endmodule

// File: rtl/pldreq_len_calc.sv
module pldreq_len_calc
  import pldreq_pkg::*;
#(
  parameter int SIZE_W = 32,
  parameter int LINE_W = 18,
  parameter int PAGE_W = 12,
  parameter int LEN_W  = 18
) (
  input  mode_e              mode_i,
  input  logic [PAGE_W-1:0]  addr_lo_i,
  input  logic [SIZE_W-1:0]  rem_i,
  input  logic [LINE_W-1:0]  line_i,
  output logic [LEN_W-1:0]   len_o
);
  localparam int unsigned PAGE_B = 1 << PAGE_W;

  logic [SIZE_W-1:0] page_left;
  logic [SIZE_W-1:0] cap;

  assign page_left = SIZE_W'(PAGE_B) - SIZE_W'(addr_lo_i);

  always_comb begin
    cap   = (mode_i == MODE_FRAGS) ? page_left : SIZE_W'(line_i);
    len_o = (rem_i < cap) ? LEN_W'(rem_i) : LEN_W'(cap);
  end
endmodule

// File: rtl/pldreq_ctrl.sv
module pldreq_ctrl
  import pldreq_pkg::*;
#(
  parameter int FRAG_N = 5,
  parameter int ADDR_W = 44,
  parameter int SIZE_W = 32,
  parameter int LINE_W = 18,
  parameter int LEN_W  = 18,
  localparam int IDX_W = $clog2(FRAG_N)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          frag_mode_i,
  input  logic [SIZE_W-1:0]             xfer_size_i,
  input  logic [LINE_W-1:0]             line_size_i,
  input  logic [ADDR_W-1:0]             stride_i,
  input  logic [FRAG_N-1:0][ADDR_W-1:0] frag_addr_i,
  input  logic                          req_ready_i,
  input  logic                          mem_err_i,
  input  logic [LEN_W-1:0]              len_i,
  output logic                          busy_o,
  output mode_e                         mode_o,
  output logic [ADDR_W-1:0]             addr_o,
  output logic [SIZE_W-1:0]             rem_o,
  output logic [LINE_W-1:0]             line_o,
  output logic [ADDR_W-1:0]             stride_o,
  output logic                          done_o,
  output logic                          err_o
);
  st_e                          st_q;
  mode_e                        mode_q;
  logic [SIZE_W-1:0]            rem_q;
  logic [LINE_W-1:0]            line_q;
  logic [ADDR_W-1:0]            stride_q;
  logic [ADDR_W-1:0]            addr_q;
  logic [FRAG_N-1:0][ADDR_W-1:0] frag_q;
  logic [IDX_W-1:0]             idx_q;
  logic                         done_q, err_q;

  logic [SIZE_W-1:0] rem_nxt;
  logic              last_req;

  assign rem_nxt  = rem_q - SIZE_W'(len_i);
  assign last_req = (rem_nxt == '0) ||
                    ((mode_q == MODE_FRAGS) && (idx_q == IDX_W'(FRAG_N - 1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      mode_q   <= MODE_LINES;
      rem_q    <= '0;
      line_q   <= '0;
      stride_q <= '0;
      addr_q   <= '0;
      frag_q   <= '0;
      idx_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            mode_q   <= mode_e'(frag_mode_i);
            rem_q    <= xfer_size_i;
            line_q   <= line_size_i;
            stride_q <= stride_i;
            frag_q   <= frag_addr_i;
            addr_q   <= frag_addr_i[0];
            idx_q    <= '0;
            if (xfer_size_i == '0) begin
              done_q <= 1'b1;
            end else if (!frag_mode_i && (line_size_i == '0)) begin
              err_q <= 1'b1;  // would never consume the transfer
            end else begin
              st_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (mem_err_i) begin
            err_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else if (req_ready_i) begin
            rem_q <= rem_nxt;
            if (last_req) begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else if (mode_q == MODE_FRAGS) begin
              idx_q  <= idx_q + 1'b1;
              addr_q <= frag_q[idx_q + 1'b1];
            end else begin
              addr_q <= addr_q + stride_q;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (st_q == ST_RUN);
  assign mode_o   = mode_q;
  assign addr_o   = addr_q;
  assign rem_o    = rem_q;
  assign line_o   = line_q;
  assign stride_o = stride_q;
  assign done_o   = done_q;
  assign err_o    = err_q;
endmodule

// File: rtl/pldreq_gen.sv
module pldreq_gen
  import pldreq_pkg::*;
#(
  parameter int FRAG_N       = 5,
  parameter int BASE_W       = 32,
  parameter int EXT_W        = 12,
  parameter int WORD_W       = 32,
  parameter int SIZE_W       = 32,
  parameter int LINE_W       = 18,
  parameter int STRIDE_SHIFT = 4,
  parameter int PAGE_W       = 12,
  localparam int ADDR_W      = BASE_W + EXT_W,
  localparam int EXT_WORDS   = (FRAG_N + 2) / 2,
  localparam int LEN_W       = (LINE_W > PAGE_W + 1) ? LINE_W : PAGE_W + 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             start_i,
  input  logic                             frag_mode_i,
  input  logic [SIZE_W-1:0]                xfer_size_i,
  input  logic [WORD_W-1:0]                line_word_i,
  input  logic [FRAG_N-1:0][BASE_W-1:0]    src_base_i,
  input  logic [EXT_WORDS-1:0][WORD_W-1:0] addr_ext_i,
  output logic                             req_valid_o,
  input  logic                             req_ready_i,
  output logic [ADDR_W-1:0]                req_addr_o,
  output logic [LEN_W-1:0]                 req_len_o,
  input  logic                             mem_err_i,
  output logic                             done_o,
  output logic                             err_o
);
  localparam int STRIDE_W = WORD_W - LINE_W;

  logic [FRAG_N-1:0][ADDR_W-1:0] frag_addr;
  logic [ADDR_W-1:0]             stride_in;
  mode_e                         run_mode;
  logic [SIZE_W-1:0]             run_rem;
  logic [LINE_W-1:0]             run_line;
  logic [ADDR_W-1:0]             run_stride;

  assign stride_in = ADDR_W'({line_word_i[WORD_W-1:LINE_W], {STRIDE_SHIFT{1'b0}}});

  pldreq_frag_addr #(
    .FRAG_N(FRAG_N), .BASE_W(BASE_W), .EXT_W(EXT_W),
    .WORD_W(WORD_W), .EXT_WORDS(EXT_WORDS), .HI_LSB(16)
  ) u_frag_addr (
    .base_i (src_base_i),
    .ext_i  (addr_ext_i),
    .addr_o (frag_addr)
  );

  pldreq_ctrl #(
    .FRAG_N(FRAG_N), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
    .LINE_W(LINE_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .frag_mode_i (frag_mode_i),
    .xfer_size_i (xfer_size_i),
    .line_size_i (line_word_i[LINE_W-1:0]),
    .stride_i    (stride_in),
    .frag_addr_i (frag_addr),
    .req_ready_i (req_ready_i),
    .mem_err_i   (mem_err_i),
    .len_i       (req_len_o),
    .busy_o      (req_valid_o),
    .mode_o      (run_mode),
    .addr_o      (req_addr_o),
    .rem_o       (run_rem),
    .line_o      (run_line),
    .stride_o    (run_stride),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  pldreq_len_calc #(
    .SIZE_W(SIZE_W), .LINE_W(LINE_W), .PAGE_W(PAGE_W), .LEN_W(LEN_W)
  ) u_len (
    .mode_i    (run_mode),
    .addr_lo_i (req_addr_o[PAGE_W-1:0]),
    .rem_i     (run_rem),
    .line_i    (run_line),
    .len_o     (req_len_o)
  );

  logic unused_stride_hi;
  assign unused_stride_hi = ^STRIDE_W;
endmodule

// File: rtl/pldreq_gen_chk.sv
module pldreq_gen_chk
  import pldreq_pkg::*;
#(
  parameter int ADDR_W = 44,
  parameter int LEN_W  = 18,
  parameter int PAGE_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [LEN_W-1:0]  req_len_o,
  input logic              mem_err_i,
  input logic              done_o,
  input logic              err_o,
  input mode_e             mode_i,
  input logic [ADDR_W-1:0] stride_i
);
  a_r1_idle_reset: assert property (@(posedge clk_i)
    !rst_ni |-> !req_valid_o && !done_o && !err_o);

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i && !mem_err_i
    |=> req_valid_o && $stable(req_addr_o) && $stable(req_len_o));

  a_r4_page_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && mode_i == MODE_FRAGS
    |-> (32'(req_len_o) + 32'(req_addr_o[PAGE_W-1:0])) <= 32'(1 << PAGE_W));

  a_r2_stride_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ready_i && !mem_err_i && mode_i == MODE_LINES
    |=> !req_valid_o || (req_addr_o == $past(req_addr_o) + $past(stride_i)));

  a_r7_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && mem_err_i |=> !req_valid_o && err_o && !done_o);

  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  a_r11_len_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_len_o != '0);
endmodule

bind pldreq_gen pldreq_gen_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_addr_o  (req_addr_o),
  .req_len_o   (req_len_o),
  .mem_err_i   (mem_err_i),
  .done_o      (done_o),
  .err_o       (err_o),
  .mode_i      (run_mode),
  .stride_i    (run_stride)
);

// File: tb/tb_pldreq_gen.sv
module tb_pldreq_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              start_i = 1'b0, frag_mode_i = 1'b0;
  logic [31:0]       xfer_size_i = '0, line_word_i = '0;
  logic [4:0][31:0]  src_base_i = '0;
  logic [2:0][31:0]  addr_ext_i = '0;
  logic              req_ready_i = 1'b0, mem_err_i = 1'b0;
  logic              req_valid_o, done_o, err_o;
  logic [43:0]       req_addr_o;
  logic [17:0]       req_len_o;

  pldreq_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .frag_mode_i(frag_mode_i),
    .xfer_size_i(xfer_size_i), .line_word_i(line_word_i), .src_base_i(src_base_i),
    .addr_ext_i(addr_ext_i), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_addr_o(req_addr_o), .req_len_o(req_len_o), .mem_err_i(mem_err_i),
    .done_o(done_o), .err_o(err_o)
  );

  int n_chk = 0, n_bad = 0;
  logic [43:0] exp_addr [64];
  int          exp_len  [64];
  int          exp_n;
  bit          exp_err, exp_cap5;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] ext_of(input int f, input logic [2:0][31:0] ex);
    case (f)
      0: return ex[0][27:16];
      1: return ex[1][11:0];
      2: return ex[1][27:16];
      3: return ex[2][11:0];
      default: return ex[2][27:16];
    endcase
  endfunction

  task automatic build_exp(input bit fm, input logic [31:0] xs, input logic [31:0] lw,
                           input logic [4:0][31:0] bs, input logic [2:0][31:0] ex);
    longint rem = xs;
    longint line = lw[17:0];
    logic [43:0] a;
    exp_n = 0; exp_cap5 = 0;
    exp_err = !fm && line == 0 && xs != 0;
    if (!fm && !exp_err) begin
      a = {ex[0][27:16], bs[0]};
      while (rem > 0 && exp_n < 64) begin
        exp_addr[exp_n] = a;
        exp_len[exp_n]  = int'((rem < line) ? rem : line);
        rem -= exp_len[exp_n];
        a = a + 44'({lw[31:18], 4'b0000});
        exp_n++;
      end
    end else if (fm) begin
      for (int f = 0; f < 5; f++) begin
        if (rem > 0) begin
          longint pl;
          a  = {ext_of(f, ex), bs[f]};
          pl = 4096 - longint'(a % 4096);
          exp_addr[exp_n] = a;
          exp_len[exp_n]  = int'((rem < pl) ? rem : pl);
          rem -= exp_len[exp_n];
          exp_n++;
        end
      end
      exp_cap5 = rem > 0;
    end
  endtask

  // err_at < 0: no abort. pat 0: always ready, else ready low every (pat+1)th cycle.
  task automatic run_job(input bit fm, input logic [31:0] xs, input logic [31:0] lw,
                         input logic [4:0][31:0] bs, input logic [2:0][31:0] ex,
                         input int pat, input bit poke, input int err_at);
    int k = 0, cyc = 0;
    bit held = 0, rdy;
    logic [43:0] h_addr;
    logic [17:0] h_len;
    string tag;
    build_exp(fm, xs, lw, bs, ex);
    tag = poke ? "R10" : (fm ? "R4" : "R2");
    @(negedge clk);
    frag_mode_i = fm; xfer_size_i = xs; line_word_i = lw;
    src_base_i = bs; addr_ext_i = ex; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (exp_err) begin
      check(err_o && !done_o && !req_valid_o, "R8", "zero line err",
            {err_o, done_o, req_valid_o}, 3'b100);
      return;
    end
    if (exp_n == 0) begin
      check(done_o && !err_o && !req_valid_o, "R9", "zero size done",
            {done_o, err_o, req_valid_o}, 3'b100);
      return;
    end
    while (k < exp_n && cyc < 4000) begin
      start_i = poke && cyc == 1;
      if (poke && cyc == 1) begin
        xfer_size_i = 32'd3; frag_mode_i = ~fm; src_base_i = '0; line_word_i = 32'd1;
      end
      rdy = (pat == 0) || (cyc % (pat + 1) != 0);
      if (!req_valid_o) begin
        check(0, "R6", "valid dropped", 0, 1);
        break;
      end
      if (held) begin
        check(req_addr_o == h_addr && req_len_o == h_len, "R6", "held request",
              req_addr_o, h_addr);
        held = 0;
      end
      if (err_at == k) begin
        req_ready_i = 1'b0; mem_err_i = 1'b1;
        @(negedge clk);
        mem_err_i = 1'b0;
        check(!req_valid_o && err_o && !done_o, "R7", "abort",
              {req_valid_o, err_o, done_o}, 3'b010);
        @(negedge clk);
        check(!req_valid_o && !err_o, "R7", "stays idle", {req_valid_o, err_o}, 2'b00);
        return;
      end
      req_ready_i = rdy;
      if (rdy) begin
        check(req_addr_o == exp_addr[k], tag, $sformatf("addr #%0d", k),
              req_addr_o, exp_addr[k]);
        check(int'(req_len_o) == exp_len[k], tag, $sformatf("len #%0d", k),
              req_len_o, exp_len[k]);
        k++;
      end else begin
        held = 1; h_addr = req_addr_o; h_len = req_len_o;
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0; req_ready_i = 1'b0;
    check(k == exp_n, fm ? "R5" : "R3", "request count", k, exp_n);
    check(done_o && !err_o && !req_valid_o, (fm && exp_cap5) ? "R5" : "R3", "done pulse",
          {done_o, err_o, req_valid_o}, 3'b100);
    @(negedge clk);
    check(!done_o && !req_valid_o, "R11", "done one cycle", {done_o, req_valid_o}, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int lines[5]   = '{1, 5, 16, 64, 1000};
    int strides[4] = '{0, 1, 3, 16383};
    int offs[4]    = '{0, 1, 2048, 4095};
    int sizes[6]   = '{1, 4096, 5000, 12000, 20000, 30000};
    logic [4:0][31:0] bs;
    logic [2:0][31:0] ex;

    repeat (3) @(negedge clk);
    check(!req_valid_o && !done_o && !err_o, "R1", "in reset",
          {req_valid_o, done_o, err_o}, 3'b000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!req_valid_o && !done_o && !err_o, "R1", "after reset",
          {req_valid_o, done_o, err_o}, 3'b000);

    ex = '{32'h0ABC_0DEF, 32'h0456_0123, 32'h0789_0CDE};
    // R2/R3 sweep of line mode
    for (int li = 0; li < 5; li++)
      for (int si = 0; si < 4; si++)
        for (int xi = 0; xi < 2; xi++) begin
          int xs = 4 * lines[li] + ((xi == 1) ? (lines[li] + 1) / 2 : 0);
          bs = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h1000_0000 + 32'(li * 256)};
          run_job(1'b0, 32'(xs), {14'(strides[si]), 18'(lines[li])}, bs, ex,
                  (li + si) % 3, 1'b0, -1);
        end
    // R2 address wrap at 2^44
    bs = '{32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFF0};
    run_job(1'b0, 32'd64, {14'h3FFF, 18'd16}, bs, '{32'h0, 32'h0, 32'h0FFF_0000}, 1, 1'b0, -1);

    // R4/R5 sweep of fragment mode
    for (int oi = 0; oi < 4; oi++)
      for (int zi = 0; zi < 6; zi++) begin
        for (int f = 0; f < 5; f++)
          bs[f] = 32'h2000_0000 + 32'(f * 32'h0010_0000) + 32'(offs[(oi + f) % 4]);
        run_job(1'b1, 32'(sizes[zi]), 32'h0, bs, ex, zi % 3, 1'b0, -1);
      end

    // R10 restart while busy, both modes
    bs = '{32'h4000_0F00, 32'h4000_0800, 32'h4000_0400, 32'h4000_0010, 32'h3000_0000};
    run_job(1'b1, 32'd9000, 32'h0, bs, ex, 0, 1'b1, -1);
    run_job(1'b0, 32'd40, {14'd2, 18'd8}, bs, ex, 2, 1'b1, -1);

    // R7 abort in both modes
    run_job(1'b1, 32'd20000, 32'h0, bs, ex, 0, 1'b0, 1);
    run_job(1'b0, 32'd40, {14'd2, 18'd8}, bs, ex, 1, 1'b0, 2);
    run_job(1'b0, 32'd40, {14'd2, 18'd8}, bs, ex, 0, 1'b0, 0);

    // R8 zero line size, R9 zero transfer size
    run_job(1'b0, 32'd10, {14'd3, 18'd0}, bs, ex, 0, 1'b0, -1);
    run_job(1'b0, 32'd0, {14'd3, 18'd0}, bs, ex, 0, 1'b0, -1);
    run_job(1'b0, 32'd0, {14'd3, 18'd7}, bs, ex, 0, 1'b0, -1);
    run_job(1'b1, 32'd0, 32'h0, bs, ex, 0, 1'b0, -1);
    // back to normal after error paths
    run_job(1'b1, 32'd300, 32'h0, bs, ex, 1, 1'b0, -1);

    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule